// File: doc/BRIEF.md
# Multiplexed Backplane Phase Sequencer

This block steps a display driver through its backplane phases. It supports four drive modes: static, two-way, three-way and four-way multiplex. A one-cycle frame tick from the surrounding timing logic moves it one phase forward. It reports the active backplane as an index, so that the waveform generator knows which common electrode to energise.

Several drivers can be chained to share one display. To keep the chain aligned, each one connects to a shared open-drain sync line with a pull-up. A driver pulls the line low for exactly one phase, starting when it enters its own last phase; it never drives the line high. At all other times it only listens to the line. A falling edge seen while the driver is not in its last phase makes it jump straight to the last phase. The first member of the chain to pull the line therefore sets the phase for all the others. After reset every member starts at phase zero, so a chain reset together starts aligned.

Top module: `bp_sequencer`

## Requirements
- R1: During and after reset, `bpIndex` is 0 and `syncOe` is 0.
- R2: `mode` encodes the drive as 0 = static, 1 = two-way, 2 = three-way, 3 = four-way. The last phase index equals `mode`. Each `tickIn` pulse moves `bpIndex` up by one, and from the last phase it wraps to 0. The new value appears in the cycle after the tick.
- R3: When there is no tick and no realignment, `bpIndex` holds its value.
- R4: A tick that enters the last phase sets `syncOe` from the next cycle. The next tick clears it, so the drive lasts exactly one phase.
- R5: In static mode, `bpIndex` stays 0 and every tick leaves `syncOe` asserted.
- R6: `syncOe` changes only in the cycle after a tick. It is the pad's pull-low enable and is the only drive the block applies to the line.
- R7: A falling edge on `syncIn` while `bpIndex` differs from the last phase sets `bpIndex` to the last phase within four cycles. This does not assert `syncOe`.
- R8: A falling edge on `syncIn` while the block is already in its last phase has no effect on `bpIndex`.
- R9: The block ignores the falling edge of the line that its own drive causes, even when the next tick arrives in the very next cycle.
- R10: After `mode` changes, a tick made while `bpIndex` is at or beyond the new last phase wraps `bpIndex` to 0.
- R11: `syncIn` passes through a `SYNC_STAGES`-flop synchroniser whose flops reset to the idle-high level, so reset alone never produces a realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle pulse that advances the phase |
| mode | input | 2 | Drive mode, which is also the last phase index |
| bpIndex | output | 2 | Active backplane phase |
| syncOe | output | 1 | Pull-low enable for the shared sync pad |
| syncIn | input | 1 | Sampled level of the shared sync pad |

## Verification
The bound checker runs on every cycle and covers the following:
- the phase holds between events;
- a tick from the last phase wraps to zero;
- static mode stays at phase zero with the drive on;
- the pull-low enable changes only after a tick;
- a realignment strobe lands on the last phase.

Other behaviours need the bench's chained-line scenarios:
- an external pull realigns the block, with the latency that the synchroniser sets;
- a pull is ignored in the last phase;
- the block rejects its own echo during back-to-back ticks;
- the block wraps correctly after a mode change.

// File: rtl/bpseq_pkg.sv
package bpseq_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    DRV_STATIC = 2'd0,
    DRV_MUX2   = 2'd1,
    DRV_MUX3   = 2'd2,
    DRV_MUX4   = 2'd3
  } drive_mode_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic               advance;
    logic               realign;
    logic               setOe;
    logic               clrOe;
    logic [PHASE_W-1:0] target;
  } bpseq_ctl_t;
endpackage

// File: rtl/bpseq_ctrl.sv
module bpseq_ctrl
  import bpseq_pkg::*;
(
  input  logic               tickIn,
  input  logic [PHASE_W-1:0] mode,
  input  logic [PHASE_W-1:0] phase,
  input  logic               syncFall,
  output bpseq_ctl_t         ctl
);
  logic [PHASE_W-1:0] lastPh;
  logic [PHASE_W-1:0] nextPh;
  logic               atLast;
  logic               wrapNext;

  always_comb begin
    lastPh   = mode;
    atLast   = (phase == lastPh);
    wrapNext = (phase >= lastPh);
    nextPh   = wrapNext ? '0 : phase + 1'b1;

    ctl.realign = syncFall && !atLast;
    ctl.advance = tickIn && !ctl.realign;
    ctl.target  = ctl.realign ? lastPh : nextPh;
    ctl.setOe   = ctl.advance && (nextPh == lastPh);
    ctl.clrOe   = ctl.advance && (nextPh != lastPh);
  end
endmodule

// File: rtl/bpseq_dp.sv
module bpseq_dp
  import bpseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  bpseq_ctl_t         ctl,
  input  logic               syncPadIn,
  output logic [PHASE_W-1:0] phase,
  output logic               syncFall,
  output logic               syncOeQ
);
  localparam int MASK_LEN = SYNC_STAGES;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic [MASK_LEN-1:0]    oeHist;
  logic                   echoMask;

  // Input synchroniser, idle level is high
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gi] <= 1'b1;
        else if (gi == 0) syncChain[gi] <= syncPadIn;
        else syncChain[gi] <= syncChain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b1;
    else       syncPrev <= syncChain[SYNC_STAGES-1];
  end

  // History of own drive, used to hide our own echo
  generate
    for (gi = 0; gi < MASK_LEN; gi++) begin : g_hist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) oeHist[gi] <= 1'b0;
        else if (gi == 0) oeHist[gi] <= syncOeQ;
        else oeHist[gi] <= oeHist[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign echoMask = syncOeQ || (|oeHist);
  assign syncFall = syncPrev && !syncChain[SYNC_STAGES-1] && !echoMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (ctl.advance || ctl.realign) phase <= ctl.target;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          syncOeQ <= 1'b0;
    else if (ctl.setOe) syncOeQ <= 1'b1;
    else if (ctl.clrOe) syncOeQ <= 1'b0;
  end
endmodule

// File: rtl/bp_sequencer.sv
module bp_sequencer
  import bpseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic [1:0] mode,
  output logic [1:0] bpIndex,
  output logic       syncOe,
  input  logic       syncIn
);
  bpseq_ctl_t         ctlBus;
  logic [PHASE_W-1:0] phase;
  logic               syncFall;

  bpseq_ctrl u_ctrl (
    .tickIn   (tickIn),
    .mode     (mode),
    .phase    (phase),
    .syncFall (syncFall),
    .ctl      (ctlBus)
  );

  bpseq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .syncPadIn (syncIn),
    .phase     (phase),
    .syncFall  (syncFall),
    .syncOeQ   (syncOe)
  );

  assign bpIndex = phase;
endmodule

// File: rtl/bp_sequencer_chk.sv
module bp_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic [1:0] mode,
  input logic [1:0] bpIndex,
  input logic       syncOe,
  input logic       realign
);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !realign) |=> $stable(bpIndex));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !realign && bpIndex == mode) |=> (bpIndex == 2'd0));

  // R5
  static_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !realign && mode == 2'd0) |=> (bpIndex == 2'd0 && syncOe));

  // R6
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOe) |-> $past(tickIn));

  // R4
  oe_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncOe) |-> $past(tickIn));

  // R7
  realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    realign |=> (bpIndex == $past(mode)));
endmodule

bind bp_sequencer bp_sequencer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickIn  (tickIn),
  .mode    (mode),
  .bpIndex (bpIndex),
  .syncOe  (syncOe),
  .realign (ctlBus.realign)
);

// File: tb/sim_bp_sequencer.sv
`timescale 1ns/1ps
module sim_bp_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [1:0] mode = 2'd3;
  logic [1:0] bpIndex;
  logic       syncOe;
  logic       extLow = 1'b0;
  logic       padLevel;

  int testsRun = 0;
  int testsFail = 0;
  int cycleCnt = 0;
  bit doneFlag = 0;

  typedef struct {
    int         due;
    logic [1:0] idx;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Wired-AND line: pulled low by this device or the remote one
  assign padLevel = !syncOe && !extLow;

  bp_sequencer u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .mode(mode),
    .bpIndex(bpIndex), .syncOe(syncOe), .syncIn(padLevel)
  );

  task automatic check(input string tag, input logic [1:0] idx, input logic oe);
    testsRun++;
    if (bpIndex !== idx || syncOe !== oe) begin
      testsFail++;
      $display("FAIL %s: got idx=%0d oe=%0b, expected idx=%0d oe=%0b",
               tag, bpIndex, syncOe, idx, oe);
    end
  endtask

  // Monitor: compare queued expectations once their cycle has arrived
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, e.idx, e.oe);
    end
  end

  // Driver: one tick, called at a negedge, leaves the bench at the next negedge
  task automatic doTick(input logic [1:0] idx, input logic oe, input string tag);
    exp_t e;
    tickIn = 1'b1;
    e.due = cycleCnt + 1; e.idx = idx; e.oe = oe; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    check("R1 in reset", 2'd0, 1'b0);
    rstN = 1'b1;
    idle(6);
    check("R1 after reset", 2'd0, 1'b0);
    check("R11 no realign from reset", 2'd0, 1'b0);

    // four-way multiplex sequence
    doTick(2'd1, 1'b0, "R2 mux4 step1"); idle(4);
    check("R3 hold between ticks", 2'd1, 1'b0);
    doTick(2'd2, 1'b0, "R2 mux4 step2"); idle(4);
    doTick(2'd3, 1'b1, "R4 mux4 enter last"); idle(4);
    check("R4 drive held in last phase", 2'd3, 1'b1);
    doTick(2'd0, 1'b0, "R4 mux4 wrap release"); idle(4);

    // static drive
    mode = 2'd0; idle(1);
    doTick(2'd0, 1'b1, "R5 static tick1"); idle(3);
    doTick(2'd0, 1'b1, "R5 static tick2"); idle(3);

    // two-way
    mode = 2'd1; idle(1);
    doTick(2'd1, 1'b1, "R2 mux2 last"); idle(3);
    doTick(2'd0, 1'b0, "R2 mux2 wrap"); idle(3);
    doTick(2'd1, 1'b1, "R2 mux2 last again"); idle(3);

    // three-way
    mode = 2'd2; idle(1);
    doTick(2'd2, 1'b1, "R2 mux3 last"); idle(3);
    doTick(2'd0, 1'b0, "R2 mux3 wrap"); idle(3);
    doTick(2'd1, 1'b0, "R2 mux3 step"); idle(3);

    // remote realignment while in phase 1 of four-way
    mode = 2'd3; idle(2);
    check("R6 mode change alone keeps drive", 2'd1, 1'b0);
    extLow = 1'b1; idle(4);
    check("R7 realigned to last", 2'd3, 1'b0);
    extLow = 1'b0; idle(6);
    extLow = 1'b1; idle(5);
    check("R8 edge in last phase ignored", 2'd3, 1'b0);
    extLow = 1'b0; idle(6);
    doTick(2'd0, 1'b0, "R7 after realign wrap"); idle(4);

    // back-to-back ticks: own echo must not realign
    doTick(2'd1, 1'b0, "R9 b2b 1");
    doTick(2'd2, 1'b0, "R9 b2b 2");
    doTick(2'd3, 1'b1, "R9 b2b 3");
    doTick(2'd0, 1'b0, "R9 b2b 0");
    doTick(2'd1, 1'b0, "R9 b2b 1b");
    doTick(2'd2, 1'b0, "R9 b2b 2b");
    idle(8);
    check("R9 no realign from own echo", 2'd2, 1'b0);

    // mode shrink while beyond new last phase
    doTick(2'd3, 1'b1, "R10 reach phase3"); idle(3);
    mode = 2'd1; idle(1);
    doTick(2'd0, 1'b0, "R10 wrap after shrink"); idle(3);
    doTick(2'd1, 1'b1, "R10 new last"); idle(3);

    idle(4);
    finishRun();
  end
endmodule